// File: doc/BRIEF.md
# Double-Buffered Frequency Control Register Bank

This block is the write side of the control registers for a numerically controlled oscillator. A host writes bytes through a synchronous write port with 16 addresses and 8 data bits. The bytes build a 48-bit center frequency word, a 48-bit offset frequency word, a serial-input control byte, an accumulator control byte and a timing byte. Every written byte first lands in a holding copy. The oscillator datapath sees only the active copy.

An update event copies all holding bytes into the active copy on a single clock edge, so a multi-byte word never reaches the datapath half written. An update comes from one of two sources. The first is a write to the highest address, which has no storage behind it. The second is a rising edge on an external strobe, which is first synchronised to the clock. After reset both copies hold values that make the center word alone produce one quarter of the clock rate.

Top module: `fcw_regbank`

## Requirements
- R1: The center frequency word `center_word` is built from addresses 0 to 5: address 0 supplies bits 7:0 and address 5 supplies bits 47:40. Each byte reaches the output only through an update.
- R2: The offset frequency word `offset_word` is built from addresses 6 to 11 with the same byte order: address 6 supplies bits 7:0 and address 11 supplies bits 47:40.
- R3: While `rst` is high at a clock edge, the following values load into both copies: `center_word` = 48'h4000_0000_0000, `offset_word` = 0, `serial_ctl` = 8'h01, `accum_ctl` = 8'hF8, `timing_ctl` = 8'h10. `upd_done` goes to 0.
- R4: Address 12 feeds `serial_ctl`, address 13 feeds `accum_ctl` and address 14 feeds `timing_ctl`. All three are double-buffered like the frequency words.
- R5: A write to address 15 causes an update at that same clock edge. It stores nothing, so all five outputs take exactly the holding contents.
- R6: A write to addresses 0 to 14 leaves every output unchanged until an update occurs.
- R7: A rising edge on `upd_in` that is held through the edge where it is first sampled (edge E1) loads the active copy at edge E1+2. While `upd_in` stays high it causes no further update.
- R8: An update copies the holding contents as they stood before the update edge. If a byte is written on the same edge, the new byte stays in the holding copy only.
- R9: `upd_done` is 1 during the cycle after each edge at which an update occurred, and 0 otherwise.
- R10: When `wr_en` is low, `wr_addr` and `wr_data` have no effect on either copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 4 | Byte address |
| wr_data | input | 8 | Byte to write |
| upd_in | input | 1 | External update strobe, asynchronous to `clk` |
| center_word | output | 48 | Active center frequency word |
| offset_word | output | 48 | Active offset frequency word |
| serial_ctl | output | 8 | Active serial-input control byte |
| accum_ctl | output | 8 | Active accumulator control byte |
| timing_ctl | output | 8 | Active timing control byte |
| upd_done | output | 1 | Marks the cycle after an update |

## Verification
The bench writes random bytes and checks that no output moves before an update. A design that wrote straight into the active copy would show single bytes changing early. It writes to address 15 in the middle of partial word writes, which catches a design that drops the command or shifts the byte order. It steps an external strobe edge by edge: an update one cycle early points to a missing synchroniser stage, and repeated updates while the strobe is held show that edge detection is missing. It also writes a byte on the same edge as a strobe update, which catches an active copy that captures the new byte instead of the old holding value.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
  localparam int unsigned BYTE_W = 8;

  // Reset value of a holding/active byte, given its index and the word size in bytes.
  function automatic logic [BYTE_W-1:0] reset_byte(input int unsigned idx,
                                                   input int unsigned word_bytes);
    logic [BYTE_W-1:0] v;
    v = '0;
    if (idx == word_bytes - 1)          v = 8'h40;  // center MSB: quarter clock rate
    else if (idx == 2*word_bytes)       v = 8'h01;  // serial control
    else if (idx == 2*word_bytes + 1)   v = 8'hF8;  // accumulator control
    else if (idx == 2*word_bytes + 2)   v = 8'h10;  // timing control
    return v;
  endfunction
endpackage

// File: rtl/fcw_upd_sync.sv
module fcw_upd_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic pulse
);
  logic [SYNC_STAGES-1:0] sr;
  logic                   prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[SYNC_STAGES-2:0], async_in};
      prev <= sr[SYNC_STAGES-1];
    end
  end

  assign pulse = sr[SYNC_STAGES-1] & ~prev;
endmodule

// File: rtl/fcw_hold_bank.sv
module fcw_hold_bank
  import fcw_pkg::*;
#(
  parameter int unsigned NREG       = 15,
  parameter int unsigned WORD_BYTES = 6,
  parameter int unsigned AW         = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic [NREG*BYTE_W-1:0] hold_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_byte
    localparam logic [BYTE_W-1:0] RV = reset_byte(i, WORD_BYTES);
    always_ff @(posedge clk) begin
      if (rst)
        hold_flat[i*BYTE_W +: BYTE_W] <= RV;
      else if (wr_en && (wr_addr == AW'(i)))
        hold_flat[i*BYTE_W +: BYTE_W] <= wr_data;
    end
  end
endmodule

// File: rtl/fcw_active_bank.sv
module fcw_active_bank
  import fcw_pkg::*;
#(
  parameter int unsigned NREG       = 15,
  parameter int unsigned WORD_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [NREG*BYTE_W-1:0] hold_flat,
  output logic [NREG*BYTE_W-1:0] act_flat,
  output logic                   load_done
);
  for (genvar i = 0; i < NREG; i++) begin : g_byte
    localparam logic [BYTE_W-1:0] RV = reset_byte(i, WORD_BYTES);
    always_ff @(posedge clk) begin
      if (rst)       act_flat[i*BYTE_W +: BYTE_W] <= RV;
      else if (load) act_flat[i*BYTE_W +: BYTE_W] <= hold_flat[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) load_done <= 1'b0;
    else     load_done <= load;
  end
endmodule

// File: rtl/fcw_regbank.sv
module fcw_regbank
  import fcw_pkg::*;
#(
  parameter int unsigned WORD_BYTES  = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_addr,
  input  logic [7:0]                    wr_data,
  input  logic                          upd_in,
  output logic [WORD_BYTES*BYTE_W-1:0]  center_word,
  output logic [WORD_BYTES*BYTE_W-1:0]  offset_word,
  output logic [7:0]                    serial_ctl,
  output logic [7:0]                    accum_ctl,
  output logic [7:0]                    timing_ctl,
  output logic                          upd_done
);
  localparam int unsigned WW       = WORD_BYTES * BYTE_W;
  localparam int unsigned CF_BASE  = 0;
  localparam int unsigned OF_BASE  = WORD_BYTES;
  localparam int unsigned SER_IDX  = 2 * WORD_BYTES;
  localparam int unsigned ACC_IDX  = SER_IDX + 1;
  localparam int unsigned TIM_IDX  = SER_IDX + 2;
  localparam int unsigned NREG     = SER_IDX + 3;
  localparam int unsigned CMD_ADDR = NREG;
  localparam int unsigned AW       = 4;

  logic [NREG*BYTE_W-1:0] hold_flat;
  logic [NREG*BYTE_W-1:0] act_flat;
  logic                   upd_ext;
  logic                   upd_cmd;
  logic                   upd_fire;

  fcw_hold_bank #(.NREG(NREG), .WORD_BYTES(WORD_BYTES), .AW(AW)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hold_flat(hold_flat)
  );

  fcw_upd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(upd_in), .pulse(upd_ext)
  );

  assign upd_cmd  = wr_en && (wr_addr == AW'(CMD_ADDR));
  assign upd_fire = upd_cmd | upd_ext;

  fcw_active_bank #(.NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_act (
    .clk(clk), .rst(rst), .load(upd_fire), .hold_flat(hold_flat),
    .act_flat(act_flat), .load_done(upd_done)
  );

  assign center_word = act_flat[CF_BASE*BYTE_W +: WW];
  assign offset_word = act_flat[OF_BASE*BYTE_W +: WW];
  assign serial_ctl  = act_flat[SER_IDX*BYTE_W +: BYTE_W];
  assign accum_ctl   = act_flat[ACC_IDX*BYTE_W +: BYTE_W];
  assign timing_ctl  = act_flat[TIM_IDX*BYTE_W +: BYTE_W];
endmodule

// File: rtl/fcw_regbank_chk.sv
module fcw_regbank_chk #(
  parameter int unsigned NBITS = 120,
  parameter int unsigned WW    = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [3:0]       wr_addr,
  input logic             upd_fire,
  input logic             upd_ext,
  input logic             upd_done,
  input logic [NBITS-1:0] hold_flat,
  input logic [WW-1:0]    center_word,
  input logic [WW-1:0]    offset_word,
  input logic [7:0]       serial_ctl,
  input logic [7:0]       accum_ctl,
  input logic [7:0]       timing_ctl
);
  logic [NBITS-1:0] outs;
  assign outs = {timing_ctl, accum_ctl, serial_ctl, offset_word, center_word};

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      AST_RESET_VALUES: assert (center_word == 48'h4000_0000_0000 && offset_word == '0 &&
                                serial_ctl == 8'h01 && accum_ctl == 8'hF8 &&
                                timing_ctl == 8'h10 && !upd_done); // R3
    end
  end

  AST_NO_EARLY_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !upd_fire |=> $stable(outs)); // R6

  AST_UPDATE_COPIES: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> outs == $past(hold_flat)); // R8

  AST_CMD_ADDR_UPDATES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 4'd15) |=> upd_done); // R5

  AST_EXT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    upd_ext |=> !upd_ext); // R7

  AST_DONE_MARKS_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !upd_fire |=> !upd_done); // R9
endmodule

bind fcw_regbank fcw_regbank_chk #(.NBITS(NREG*8), .WW(WW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .upd_fire(upd_fire), .upd_ext(upd_ext), .upd_done(upd_done),
  .hold_flat(hold_flat), .center_word(center_word), .offset_word(offset_word),
  .serial_ctl(serial_ctl), .accum_ctl(accum_ctl), .timing_ctl(timing_ctl)
);

// File: tb/fcw_regbank_tb.sv
module fcw_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        upd_in = 1'b0;
  logic [47:0] center_word, offset_word;
  logic [7:0]  serial_ctl, accum_ctl, timing_ctl;
  logic        upd_done;

  int checks = 0;
  int errors = 0;
  logic [7:0] hold_m [15];
  logic [7:0] act_m  [15];
  logic       exp_done = 1'b0;

  always #2.5 clk = ~clk;

  fcw_regbank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_in(upd_in), .center_word(center_word), .offset_word(offset_word),
    .serial_ctl(serial_ctl), .accum_ctl(accum_ctl), .timing_ctl(timing_ctl),
    .upd_done(upd_done)
  );

  function automatic logic [7:0] rv(int i);
    case (i)
      5: return 8'h40;
      12: return 8'h01;
      13: return 8'hF8;
      14: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [47:0] word_of(int base);
    logic [47:0] w;
    for (int b = 0; b < 6; b++) w[b*8 +: 8] = act_m[base + b];
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " center"}, 64'(center_word), 64'(word_of(0)));
    chk({req, " offset"}, 64'(offset_word), 64'(word_of(6)));
    chk({req, " serial"}, 64'(serial_ctl), 64'(act_m[12]));
    chk({req, " accum"},  64'(accum_ctl),  64'(act_m[13]));
    chk({req, " timing"}, 64'(timing_ctl), 64'(act_m[14]));
    chk({req, " done R9"}, 64'(upd_done), 64'(exp_done));
  endtask

  // One clock: drive at negedge, model the edge, check at next negedge.
  task automatic step(logic en, logic [3:0] a, logic [7:0] d, logic ext_fire, string req);
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk);
    exp_done = ext_fire || (en && a == 4'd15);
    if (exp_done) for (int i = 0; i < 15; i++) act_m[i] = hold_m[i];
    if (en && a != 4'd15) hold_m[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
    check_all(req);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 15; i++) begin hold_m[i] = rv(i); act_m[i] = rv(i); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R3 reset");
    chk("R3 center quarter rate", 64'(center_word), 64'h4000_0000_0000);

    // R1 R2 R4 R6: write every byte, outputs must not move, then command update
    for (int a = 0; a < 15; a++) step(1'b1, 4'(a), 8'(8'hA0 + a), 1'b0, "R6 buffered");
    step(1'b1, 4'd15, 8'h00, 1'b0, "R5 cmd update");
    chk("R1 byte order", 64'(center_word), 64'hA5A4_A3A2_A1A0);
    chk("R2 byte order", 64'(offset_word), 64'hABAA_A9A8_A7A6);
    chk("R4 ctl bytes", 64'({serial_ctl, accum_ctl, timing_ctl}), 64'hACADAE);

    // R10: wr_en low does nothing, even to address 15
    step(1'b0, 4'd3, 8'h55, 1'b0, "R10 no write");
    step(1'b0, 4'd15, 8'h55, 1'b0, "R10 no cmd");
    step(1'b1, 4'd15, 8'h00, 1'b0, "R10 held values");
    chk("R10 center untouched", 64'(center_word), 64'hA5A4_A3A2_A1A0);

    // R7: external strobe, two sync stages plus edge detect
    step(1'b1, 4'd0, 8'h11, 1'b0, "R6 pre strobe");
    upd_in = 1'b1;
    step(1'b0, 4'd0, 8'h00, 1'b0, "R7 edge1 no update");
    step(1'b0, 4'd0, 8'h00, 1'b0, "R7 edge2 no update");
    // R8: write on the same edge as the strobe update
    step(1'b1, 4'd1, 8'h22, 1'b1, "R7 R8 edge3 update");
    chk("R8 old byte captured", 64'(center_word[15:0]), 64'hA111);
    for (int k = 0; k < 5; k++) step(1'b0, 4'd0, 8'h00, 1'b0, "R7 held no repeat");
    upd_in = 1'b0;
    step(1'b0, 4'd0, 8'h00, 1'b0, "R7 release");
    step(1'b1, 4'd15, 8'h00, 1'b0, "R8 new byte later");
    chk("R8 second byte", 64'(center_word[15:8]), 64'h22);

    // Random traffic with occasional command writes
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      step(1'($urandom_range(0, 3) != 0), a, 8'($urandom), 1'b0, "R1 R2 R5 R6 random");
    end

    // Reset mid-stream restores both copies
    step(1'b1, 4'd5, 8'h99, 1'b0, "R6 pre reset");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 15; i++) begin hold_m[i] = rv(i); act_m[i] = rv(i); end
    exp_done = 1'b0;
    check_all("R3 re-reset");
    step(1'b1, 4'd15, 8'h00, 1'b0, "R3 holding reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule